// File: doc/BRIEF.md
# Fixed-Point Integer Unit with Condition Code

This block is the fixed-point execution unit of a small processor core. Each cycle it may accept one operation on 32-bit two's-complement integers: add, subtract, signed compare, arithmetic shift left, arithmetic shift right, or load. The first operand comes from a register. The second operand is either a full 32-bit word or a 16-bit halfword, which is sign-extended before use. Shifts take their count from a separate 6-bit input.

All outputs are registered and appear one cycle after the operation is accepted. The outputs are the result with its register-write strobe, a 2-bit condition code with its own update strobe, and a one-cycle overflow-exception pulse. The condition code is held in a register. Only the operation classes that define a code change it, so a load leaves the code from an earlier operation in place for a later conditional branch.

Top module: `int_alu_cc`

## Requirements
- R1: When `halfSel` is 1, the second operand is `opB[15:0]` sign-extended to 32 bits, and `opB[31:16]` has no effect. When `halfSel` is 0, all of `opB` is used.
- R2: Add (`opSel`=0) and subtract (`opSel`=1) write the 32-bit sum or difference. They set the code to 00 for a zero result, 01 for a negative result and 10 for a positive result.
- R3: When an add or subtract overflows, the wrapped result is still written. The code becomes 11, and `ovfExc` is high for exactly the cycle in which that result appears.
- R4: Subtracting 0x80000000 from zero returns 0x80000000, sets code 11 and raises `ovfExc`.
- R5: Compare (`opSel`=2) is signed. It sets code 00 when `opA` equals the second operand, 01 when `opA` is less and 10 when `opA` is greater. It never asserts `resWe` or `ovfExc`.
- R6: Arithmetic right shift (`opSel`=4) shifts `opA` by `shAmt` and fills the vacated bits with copies of the sign, which rounds toward minus infinity. A count of 32 or more gives all sign bits. The code is set from the result as in R2, and no overflow is raised.
- R7: Arithmetic left shift (`opSel`=3) keeps bit 31 of `opA`, shifts bits 30..0 left and fills with zeros. A count of 32 or more clears bits 30..0. If any bit shifted out of bit 30 differs from the sign, the code is 11 and `ovfExc` pulses. Otherwise the code follows R2.
- R8: Load (`opSel`=5) writes the second operand as the result. It leaves `ccOut` unchanged and does not assert `ccWe`.
- R9: Every output reflects the operation accepted at the previous rising edge. A cycle with `validIn` low, or with the unused codes 6 and 7, writes nothing, does not touch the code and raises no exception.
- R10: While `rstN` is low, `resWe`, `ccWe` and `ovfExc` are 0, and `ccOut` and `resOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | 0 add, 1 subtract, 2 compare, 3 shift left, 4 shift right, 5 load |
| opA | input | 32 | Register operand |
| opB | input | 32 | Second operand, full word or halfword in the low 16 bits |
| halfSel | input | 1 | Second operand is a sign-extended halfword |
| shAmt | input | 6 | Shift count |
| resOut | output | 32 | Result, held between writes |
| resWe | output | 1 | Result is to be written this cycle |
| ccOut | output | 2 | Registered condition code |
| ccWe | output | 1 | Condition code was updated this cycle |
| ovfExc | output | 1 | Binary-overflow exception pulse |

## Verification
Some properties are checked by assertions on every cycle. A compare never writes a result. A load never disturbs the code. An overflow pulse always comes with a fresh code of 11. Both shifts keep the sign of `opA`. The code stays frozen whenever `ccWe` is low, and idle cycles are silent. Other behaviour depends on specific operand values, and only the bench's scenarios can show it. This covers the exact sums and differences at both overflow boundaries, negation of the most negative value, and floor rounding of negative odd values on a right shift. It also covers shift counts at and beyond 32, the left-shift overflow rule, and halfword sign extension with stray upper bits. These scenarios are compared against a reference model that works on 64-bit integers.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_SLA  = 3'd3,
    OP_SRA  = 3'd4,
    OP_LOAD = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic    wrEn;     // result goes to the register file
    logic    ccEn;     // condition code register loads
    logic    ovfEn;    // operation may raise an overflow exception
    logic    cmpMode;  // code comes from the comparison, not the result
    alu_op_e op;
  } alu_ctl_t;

  localparam logic [1:0] CC_ZERO = 2'b00;
  localparam logic [1:0] CC_NEG  = 2'b01;
  localparam logic [1:0] CC_POS  = 2'b10;
  localparam logic [1:0] CC_OVF  = 2'b11;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic       validIn,
  input  logic [2:0] opSel,
  output alu_ctl_t   ctl
);

  alu_op_e opCode;
  assign opCode = alu_op_e'(opSel);

  always_comb begin
    ctl         = '0;
    ctl.op      = opCode;
    ctl.cmpMode = (opCode == OP_CMP);
    if (validIn) begin
      unique case (opCode)
        OP_ADD, OP_SUB, OP_SLA: begin
          ctl.wrEn  = 1'b1;
          ctl.ccEn  = 1'b1;
          ctl.ovfEn = 1'b1;
        end
        OP_SRA: begin
          ctl.wrEn = 1'b1;
          ctl.ccEn = 1'b1;
        end
        OP_CMP:  ctl.ccEn = 1'b1;
        OP_LOAD: ctl.wrEn = 1'b1;
        OP_RSV6, OP_RSV7: ctl.wrEn = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/int_alu_dp.sv
module int_alu_dp
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int SH_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  alu_ctl_t          ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              halfSel,
  input  logic [SH_W-1:0]   shAmt,
  output logic [DATA_W-1:0] resOut,
  output logic              resWe,
  output logic [1:0]        ccOut,
  output logic              ccWe,
  output logic              ovfExc
);

  localparam int MSB   = DATA_W - 1;
  localparam int CNT_W = $clog2(DATA_W + 1);

  // second operand, full word or sign-extended halfword
  logic [DATA_W-1:0] opBx;
  assign opBx = halfSel ? {{(DATA_W-HALF_W){opB[HALF_W-1]}}, opB[HALF_W-1:0]} : opB;

  logic [DATA_W-1:0] addRes, subRes;
  logic              addOvf, subOvf;
  assign addRes = opA + opBx;
  assign subRes = opA - opBx;
  assign addOvf = (opA[MSB] == opBx[MSB]) && (addRes[MSB] != opA[MSB]);
  assign subOvf = (opA[MSB] != opBx[MSB]) && (subRes[MSB] != opA[MSB]);

  logic isEq, isLt;
  assign isEq = (opA == opBx);
  assign isLt = ($signed(opA) < $signed(opBx));

  // shift count saturated at the word width
  logic [CNT_W-1:0] shCap;
  always_comb begin
    if ({1'b0, shAmt} > (SH_W+1)'(DATA_W)) shCap = CNT_W'(DATA_W);
    else                                   shCap = CNT_W'(shAmt);
  end

  logic [2*DATA_W-1:0] extA, slWide;
  logic [DATA_W-1:0]   slaRes, sraRes;
  logic                slaOvf;
  assign extA   = {{DATA_W{opA[MSB]}}, opA};
  assign slWide = extA << shCap;
  assign slaOvf = (slWide[2*DATA_W-1:MSB] != {(DATA_W+1){opA[MSB]}});
  assign slaRes = {opA[MSB], slWide[MSB-1:0]};
  assign sraRes = $signed(opA) >>> shCap;

  logic [DATA_W-1:0] aluRes;
  logic              aluOvf;
  always_comb begin
    aluRes = opBx;
    aluOvf = 1'b0;
    unique case (ctl.op)
      OP_ADD: begin aluRes = addRes; aluOvf = addOvf; end
      OP_SUB: begin aluRes = subRes; aluOvf = subOvf; end
      OP_SLA: begin aluRes = slaRes; aluOvf = slaOvf; end
      OP_SRA: aluRes = sraRes;
      OP_CMP, OP_LOAD, OP_RSV6, OP_RSV7: aluRes = opBx;
    endcase
  end

  logic [1:0] ccNext;
  always_comb begin
    if (ctl.cmpMode)           ccNext = isEq ? CC_ZERO : (isLt ? CC_NEG : CC_POS);
    else if (aluOvf)           ccNext = CC_OVF;
    else if (aluRes == '0)     ccNext = CC_ZERO;
    else if (aluRes[MSB])      ccNext = CC_NEG;
    else                       ccNext = CC_POS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut <= '0;
      resWe  <= 1'b0;
      ccOut  <= CC_ZERO;
      ccWe   <= 1'b0;
      ovfExc <= 1'b0;
    end else begin
      resWe  <= ctl.wrEn;
      ccWe   <= ctl.ccEn;
      ovfExc <= ctl.ovfEn & aluOvf;
      if (ctl.wrEn) resOut <= aluRes;
      if (ctl.ccEn) ccOut  <= ccNext;
    end
  end

endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  parameter int SH_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              halfSel,
  input  logic [SH_W-1:0]   shAmt,
  output logic [DATA_W-1:0] resOut,
  output logic              resWe,
  output logic [1:0]        ccOut,
  output logic              ccWe,
  output logic              ovfExc
);

  alu_ctl_t ctl;

  int_alu_ctrl u_ctrl (
    .validIn (validIn),
    .opSel   (opSel),
    .ctl     (ctl)
  );

  int_alu_dp #(.DATA_W(DATA_W), .HALF_W(HALF_W), .SH_W(SH_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .halfSel (halfSel),
    .shAmt   (shAmt),
    .resOut  (resOut),
    .resWe   (resWe),
    .ccOut   (ccOut),
    .ccWe    (ccWe),
    .ovfExc  (ovfExc)
  );

endmodule

// File: rtl/int_alu_cc_chk.sv
module int_alu_cc_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [2:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] resOut,
  input logic              resWe,
  input logic [1:0]        ccOut,
  input logic              ccWe,
  input logic              ovfExc
);

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd2) |=> (!resWe && !ovfExc));

  // R8
  load_keeps_cc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd5) |=> (!ccWe && $stable(ccOut)));

  // R3
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfExc |-> (ccWe && ccOut == 2'b11 && $past(validIn)));

  // R6
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd4) |=> (resWe && resOut[DATA_W-1] == $past(opA[DATA_W-1])));

  // R7
  sla_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opSel == 3'd3) |=> (resWe && resOut[DATA_W-1] == $past(opA[DATA_W-1])));

  // R9
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ccWe |-> $stable(ccOut));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!validIn || opSel[2:1] == 2'b11) |=> (!resWe && !ccWe && !ovfExc));

endmodule

bind int_alu_cc int_alu_cc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .validIn (validIn),
  .opSel   (opSel),
  .opA     (opA),
  .resOut  (resOut),
  .resWe   (resWe),
  .ccOut   (ccOut),
  .ccWe    (ccWe),
  .ovfExc  (ovfExc)
);

// File: tb/sim_int_alu_cc.sv
module sim_int_alu_cc;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        halfSel = 1'b0;
  logic [5:0]  shAmt = '0;
  logic [31:0] resOut;
  logic        resWe;
  logic [1:0]  ccOut;
  logic        ccWe;
  logic        ovfExc;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu_cc u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opSel(opSel), .opA(opA),
    .opB(opB), .halfSel(halfSel), .shAmt(shAmt), .resOut(resOut),
    .resWe(resWe), .ccOut(ccOut), .ccWe(ccWe), .ovfExc(ovfExc)
  );

  int vecCount  = 0;
  int missCount = 0;
  bit finished  = 0;
  logic [1:0] ccModel = 2'b00;

  function automatic logic [1:0] signCode(logic [31:0] r);
    if (r == 32'd0) return 2'b00;
    if (r[31])      return 2'b01;
    return 2'b10;
  endfunction

  task automatic checkOut(string tag, logic eWe, logic [31:0] eRes,
                          logic eCcWe, logic [1:0] eCc, logic eOvf);
    vecCount++;
    if (resWe !== eWe || (eWe && resOut !== eRes) || ccWe !== eCcWe ||
        ccOut !== eCc || ovfExc !== eOvf) begin
      missCount++;
      $display("FAIL %s: got we=%b res=%h ccWe=%b cc=%b ovf=%b expected we=%b res=%h ccWe=%b cc=%b ovf=%b",
               tag, resWe, resOut, ccWe, ccOut, ovfExc, eWe, eRes, eCcWe, eCc, eOvf);
    end
  endtask

  // one operation per cycle; the model runs on 64-bit integers
  task automatic apply(string tag, logic v, logic [2:0] op, logic [31:0] a,
                       logic [31:0] b, logic h, logic [5:0] s);
    longint av, bv, t;
    int n;
    logic [31:0] r = '0;
    logic we = 0, cw = 0, ov = 0;
    logic [1:0] cc = ccModel;
    @(negedge clk);
    validIn = v; opSel = op; opA = a; opB = b; halfSel = h; shAmt = s;
    av = longint'($signed(a));
    bv = h ? longint'($signed(b[15:0])) : longint'($signed(b));
    n  = (s > 6'd32) ? 32 : int'(s);
    if (v) begin
      case (op)
        3'd0, 3'd1: begin
          t  = (op == 3'd0) ? av + bv : av - bv;
          ov = (t > 64'sd2147483647) || (t < -64'sd2147483648);
          r  = t[31:0]; we = 1; cw = 1;
          cc = ov ? 2'b11 : signCode(r);
        end
        3'd2: begin
          cw = 1;
          cc = (av == bv) ? 2'b00 : ((av < bv) ? 2'b01 : 2'b10);
        end
        3'd3: begin
          t  = av * (64'sd1 <<< n);
          ov = (t > 64'sd2147483647) || (t < -64'sd2147483648);
          r  = {a[31], t[30:0]}; we = 1; cw = 1;
          cc = ov ? 2'b11 : signCode(r);
        end
        3'd4: begin
          t  = av >>> n;
          r  = t[31:0]; we = 1; cw = 1;
          cc = signCode(r);
        end
        3'd5: begin
          r = bv[31:0]; we = 1;
        end
        default: ;
      endcase
    end
    ccModel = cc;
    @(posedge clk);
    #1;
    checkOut(tag, we, r, cw, cc, ov);
  endtask

  initial begin : main
    logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    checkOut("R10 reset", 1'b0, 32'd0, 1'b0, 2'b00, 1'b0);
    if (resOut !== 32'd0) begin
      missCount++;
      $display("FAIL R10 reset result: got %h expected 00000000", resOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    apply("R9 idle", 0, 3'd0, 32'd5, 32'd6, 0, 0);
    // R2 add and subtract, three signs
    apply("R2 add pos", 1, 3'd0, 32'd100, 32'd23, 0, 0);
    apply("R2 add zero", 1, 3'd0, 32'd7, 32'hFFFF_FFF9, 0, 0);
    apply("R2 sub neg", 1, 3'd1, 32'd3, 32'd10, 0, 0);
    // R3 overflow both directions
    apply("R3 add ovf pos", 1, 3'd0, 32'h7FFF_FFFF, 32'd1, 0, 0);
    apply("R3 add ovf neg", 1, 3'd0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0);
    apply("R3 sub ovf", 1, 3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    apply("R3 add no ovf edge", 1, 3'd0, 32'h7FFF_FFFE, 32'd1, 0, 0);
    // R4 negate the most negative value
    apply("R4 negate max neg", 1, 3'd1, 32'd0, 32'h8000_0000, 0, 0);
    // R1 halfword operand with junk upper bits
    apply("R1 half neg", 1, 3'd0, 32'd100, 32'hABCD_FFFE, 1, 0);
    apply("R1 half pos", 1, 3'd1, 32'd0, 32'h8765_7FFF, 1, 0);
    apply("R1 half cmp", 1, 3'd2, 32'hFFFF_8000, 32'h0000_8000, 1, 0);
    // R5 compare
    apply("R5 cmp eq", 1, 3'd2, 32'd42, 32'd42, 0, 0);
    apply("R5 cmp lt signed", 1, 3'd2, 32'hFFFF_FFFF, 32'd1, 0, 0);
    apply("R5 cmp gt", 1, 3'd2, 32'd9, 32'h8000_0000, 0, 0);
    // R8 load keeps code 10 from previous compare
    apply("R8 load", 1, 3'd5, 32'd0, 32'hDEAD_BEEF, 0, 0);
    apply("R8 load half", 1, 3'd5, 32'd0, 32'h0000_8001, 1, 0);
    // R6 right shift
    apply("R6 sra floor", 1, 3'd4, 32'hFFFF_FFFB, 32'd0, 0, 6'd1);
    apply("R6 sra pos", 1, 3'd4, 32'h4000_0000, 32'd0, 0, 6'd30);
    apply("R6 sra 32", 1, 3'd4, 32'h8000_0001, 32'd0, 0, 6'd32);
    apply("R6 sra 63", 1, 3'd4, 32'h7FFF_FFFF, 32'd0, 0, 6'd63);
    apply("R6 sra 0", 1, 3'd4, 32'h8000_0000, 32'd0, 0, 6'd0);
    // R7 left shift
    apply("R7 sla ok", 1, 3'd3, 32'h0000_0003, 32'd0, 0, 6'd4);
    apply("R7 sla ovf", 1, 3'd3, 32'h4000_0000, 32'd0, 0, 6'd1);
    apply("R7 sla neg ok", 1, 3'd3, 32'hFFFF_FFFF, 32'd0, 0, 6'd31);
    apply("R7 sla neg ovf", 1, 3'd3, 32'hBFFF_FFFF, 32'd0, 0, 6'd1);
    apply("R7 sla 33", 1, 3'd3, 32'hFFFF_FFFF, 32'd0, 0, 6'd33);
    apply("R7 sla zero big", 1, 3'd3, 32'd0, 32'd0, 0, 6'd50);
    // R9 unused codes
    apply("R9 rsv6", 1, 3'd6, 32'd1, 32'd2, 0, 0);
    apply("R9 rsv7", 1, 3'd7, 32'd1, 32'd2, 0, 0);
    apply("R9 idle cmp", 0, 3'd2, 32'd1, 32'd2, 0, 0);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] ra, rb;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      ra = seed;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      rb = seed;
      apply("R9 mixed", ra[0] | ra[1], rb[2:0], ra, rb, rb[5], rb[13:8]);
    end
    apply("R9 idle end", 0, 3'd0, 32'd0, 32'd0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      missCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule